// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steers a small processor core into an interrupt handler and back again. When the core reaches an instruction boundary with a request pending and interrupts globally enabled, the sequencer takes four cycles. In the first two it pushes the return address onto the byte-wide stack, one byte per cycle, and steps the stack pointer down. In the last it loads the program counter with the request's vector, clears the global enable and acknowledges the request to the flag logic.

When the core decodes a return-from-interrupt, the sequencer takes another four cycles. It pops the two address bytes in the reverse order, steps the stack pointer up, reloads the program counter and sets the global enable again. While either sequence runs, `busy` stalls the core. Only the program counter goes on the stack. Status bits, handler code and arbitration between sources belong to other logic.

The stack pointer points at the next free byte. A push writes at the pointer and then decrements it. A pop increments the pointer and reads at the new value, which the block presents as `sp + 1` before the increment. Stack reads are combinational: `stk_rdata` is valid in the same cycle as `stk_addr`.

Top module: `irq_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `stk_we`, `stk_re`, `pc_load`, `irq_ack`, `gie_set` and `gie_clr` are all low.
- R2: Entry is accepted only while idle, in a cycle where `irq_pending`, `gie` and `insn_done` are all high. A request held while `gie` is low, or while a multi-cycle instruction is still running (no `insn_done`), starts nothing.
- R3: Entry lasts exactly four cycles after the accepting cycle. Cycles 1 and 2 write the stack, cycle 3 is quiet, and cycle 4 asserts `pc_load` with `pc_load_val` equal to the vector. `busy` is high in all four cycles.
- R4: In entry cycle 1 the block writes the low byte of the return address at `stk_addr = sp`. In cycle 2 it writes the high byte, zero-padded to 8 bits, at the stack pointer as already decremented. Each of these cycles pulses `sp_dec`, so the stack pointer ends two lower.
- R5: In entry cycle 4, `irq_ack` and `gie_clr` are high for that single cycle.
- R6: A return starts from idle when `reti_dec` is high and lasts four cycles. Cycle 1 reads the high byte at `sp + 1` and cycle 2 reads the low byte at `sp + 1`, each pulsing `sp_inc`. Cycle 3 is quiet. Cycle 4 loads the program counter with the popped address, truncated to `PC_W` bits, and pulses `gie_set`.
- R7: Each entry writes exactly two bytes to the stack and a return writes none. No status state is stored. `stk_we` and `stk_re` are never high together.
- R8: `insn_done`, `reti_dec` and `irq_pending` are ignored while `busy` is high. After a return, no entry starts until the core reports the completion of one more instruction with `insn_done`.
- R9: If `reti_dec` and an acceptable request arrive in the same idle cycle, the return sequence runs.
- R10: The vector and the return address (`pc_next`) are captured in the accepting cycle. Later changes on those inputs do not alter the pushed bytes or the loaded vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pending | input | 1 | A prioritized interrupt request is pending |
| irq_vector | input | PC_W | Handler address of the pending request |
| insn_done | input | 1 | The current instruction completes in this cycle |
| reti_dec | input | 1 | A return-from-interrupt instruction is decoded |
| gie | input | 1 | Global interrupt enable bit |
| pc_next | input | PC_W | Address to resume at after the handler |
| sp | input | SP_W | Current stack pointer |
| stk_rdata | input | 8 | Stack read data for `stk_addr` |
| stk_addr | output | SP_W | Stack byte address |
| stk_we | output | 1 | Stack byte write strobe |
| stk_wdata | output | 8 | Stack byte write data |
| stk_re | output | 1 | Stack byte read strobe |
| sp_dec | output | 1 | Decrement the stack pointer by one at this edge |
| sp_inc | output | 1 | Increment the stack pointer by one at this edge |
| pc_load | output | 1 | Load the program counter |
| pc_load_val | output | PC_W | Program counter value to load |
| gie_clr | output | 1 | Clear the global interrupt enable |
| gie_set | output | 1 | Set the global interrupt enable |
| irq_ack | output | 1 | One-cycle acknowledge to the flag logic |
| busy | output | 1 | A sequence is running; the core stalls |

## Verification
The bench builds the block with `PC_W = 12` and `SP_W = 10`. These values leave the return address's high byte only four bits wide, so the zero padding on the push and the truncation on the reload are both exercised. The narrow stack pointer keeps the bench's stack model small. A core model around the block applies the stack-pointer and enable strobes. Directed tasks then check pushed bytes, popped values and pointer movement against addresses computed from the requirements.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int PC_W = 16,
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_pending,
  input  logic [PC_W-1:0] irq_vector,
  input  logic            insn_done,
  input  logic            reti_dec,
  input  logic            gie,
  input  logic [PC_W-1:0] pc_next,
  input  logic [SP_W-1:0] sp,
  input  logic [7:0]      stk_rdata,
  output logic [SP_W-1:0] stk_addr,
  output logic            stk_we,
  output logic [7:0]      stk_wdata,
  output logic            stk_re,
  output logic            sp_dec,
  output logic            sp_inc,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_load_val,
  output logic            gie_clr,
  output logic            gie_set,
  output logic            irq_ack,
  output logic            busy
);

  initial assert (PC_W > 8 && PC_W <= 16);

  typedef enum logic [3:0] {
    S_IDLE, S_E1, S_E2, S_E3, S_E4, S_R1, S_R2, S_R3, S_R4
  } st_t;

  st_t st, st_nx;
  logic [PC_W-1:0] ret_pc, vec;
  logic [7:0]      pop_hi, pop_lo;
  logic [15:0]     ret_ext, popped;
  logic            start_ret, accept;

  assign start_ret = (st == S_IDLE) && reti_dec;
  assign accept    = (st == S_IDLE) && !reti_dec && irq_pending && gie && insn_done;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (start_ret) st_nx = S_R1;
              else if (accept) st_nx = S_E1;
      S_E1:   st_nx = S_E2;
      S_E2:   st_nx = S_E3;
      S_E3:   st_nx = S_E4;
      S_E4:   st_nx = S_IDLE;
      S_R1:   st_nx = S_R2;
      S_R2:   st_nx = S_R3;
      S_R3:   st_nx = S_R4;
      S_R4:   st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ret_pc <= '0;
      vec    <= '0;
      pop_hi <= '0;
      pop_lo <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        ret_pc <= pc_next;
        vec    <= irq_vector;
      end
      if (st == S_R1) pop_hi <= stk_rdata;
      if (st == S_R2) pop_lo <= stk_rdata;
    end
  end

  assign ret_ext     = 16'(ret_pc);
  assign popped      = {pop_hi, pop_lo};

  assign stk_we      = (st == S_E1) || (st == S_E2);
  assign stk_re      = (st == S_R1) || (st == S_R2);
  assign stk_wdata   = (st == S_E1) ? ret_ext[7:0] : ret_ext[15:8];
  assign stk_addr    = stk_re ? sp + SP_W'(1) : sp;
  assign sp_dec      = stk_we;
  assign sp_inc      = stk_re;
  assign pc_load     = (st == S_E4) || (st == S_R4);
  assign pc_load_val = (st == S_E4) ? vec : popped[PC_W-1:0];
  assign gie_clr     = (st == S_E4);
  assign irq_ack     = (st == S_E4);
  assign gie_set     = (st == S_R4);
  assign busy        = (st != S_IDLE);

  // R1: nothing is driven out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !busy && !stk_we && !stk_re && !pc_load);

  a_r2_no_entry_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !gie && !reti_dec) |=> !busy);

  a_r3_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_we) |=> stk_we);

  a_r3_vector_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |=> (!stk_we && !pc_load) ##1 (pc_load && irq_ack));

  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  a_r5_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (gie_clr && pc_load && !gie_set));

  a_r6_return_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_re) |=> stk_re ##1 !stk_re ##1 (pc_load && gie_set && !irq_ack));

  a_r7_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re));

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> busy);

endmodule

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int PC_W  = 12;
  localparam int SP_W  = 10;

  logic clk = 0, rst_n = 0;
  logic irq_pending = 0, insn_done = 0, reti_dec = 0;
  logic [PC_W-1:0] irq_vector = '0, pc_next = '0;
  logic [SP_W-1:0] stk_addr, sp_m;
  logic [7:0] stk_wdata, stk_rdata;
  logic stk_we, stk_re, sp_dec, sp_inc, pc_load, gie_clr, gie_set, irq_ack, busy;
  logic [PC_W-1:0] pc_load_val;
  logic gie_m, gie_wr = 0, gie_wv = 0;
  logic [7:0] mem [0:(1<<SP_W)-1];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_seq #(.PC_W(PC_W), .SP_W(SP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_vector(irq_vector),
    .insn_done(insn_done), .reti_dec(reti_dec), .gie(gie_m), .pc_next(pc_next),
    .sp(sp_m), .stk_rdata(stk_rdata), .stk_addr(stk_addr), .stk_we(stk_we),
    .stk_wdata(stk_wdata), .stk_re(stk_re), .sp_dec(sp_dec), .sp_inc(sp_inc),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .gie_clr(gie_clr),
    .gie_set(gie_set), .irq_ack(irq_ack), .busy(busy));

  assign stk_rdata = mem[stk_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_m  <= 10'h3F0;
      gie_m <= 1'b0;
    end else begin
      if (stk_we) mem[stk_addr] <= stk_wdata;
      if (sp_dec) sp_m <= sp_m - 1'b1;
      else if (sp_inc) sp_m <= sp_m + 1'b1;
      if (gie_wr) gie_m <= gie_wv;
      else if (gie_clr) gie_m <= 1'b0;
      else if (gie_set) gie_m <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_gie(input bit v);
    @(negedge clk); gie_wr = 1; gie_wv = v;
    @(negedge clk); gie_wr = 0;
  endtask

  task automatic quiet_cycle(input string tag);
    chk(!busy && !stk_we && !stk_re && !pc_load, tag, {busy, stk_we, stk_re, pc_load}, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    quiet_cycle("R1 reset outputs");
    chk(!irq_ack && !gie_set && !gie_clr, "R1 reset strobes", {irq_ack, gie_set, gie_clr}, 0);
  endtask

  task automatic t_disabled;
    @(negedge clk);
    irq_pending = 1; insn_done = 1; irq_vector = 12'h100;
    @(negedge clk); quiet_cycle("R2 gie low blocks entry");
    @(negedge clk); quiet_cycle("R2 gie low blocks entry later");
    insn_done = 0; irq_pending = 0;
  endtask

  task automatic t_entry(input logic [PC_W-1:0] vecv, input logic [PC_W-1:0] rpc,
                         input bit multi);
    logic [SP_W-1:0] sp0;
    @(negedge clk);
    sp0 = sp_m;
    irq_pending = 1; irq_vector = vecv; pc_next = rpc;
    if (multi) begin
      insn_done = 0;
      @(negedge clk); quiet_cycle("R2 no entry mid instruction");
      @(negedge clk); quiet_cycle("R2 no entry mid instruction 2");
    end
    insn_done = 1;
    @(negedge clk);
    insn_done = 0; irq_vector = ~vecv; pc_next = ~rpc;
    chk(busy && stk_we && sp_dec && stk_addr == sp0, "R4 push low addr", stk_addr, sp0);
    chk(stk_wdata == rpc[7:0], "R4 push low data", stk_wdata, rpc[7:0]);
    @(negedge clk);
    chk(stk_we && sp_dec && stk_addr == sp0 - 1, "R4 push high addr", stk_addr, sp0 - 1);
    chk(stk_wdata == {4'h0, rpc[11:8]}, "R10 push high data", stk_wdata, {4'h0, rpc[11:8]});
    @(negedge clk);
    chk(busy && !stk_we && !pc_load && !irq_ack, "R3 third cycle quiet", {stk_we, pc_load}, 0);
    @(negedge clk);
    chk(pc_load && pc_load_val == vecv, "R3 vector load", pc_load_val, vecv);
    chk(irq_ack && gie_clr && busy, "R5 ack and gie clear", {irq_ack, gie_clr}, 3);
    irq_pending = 0;
    @(negedge clk);
    chk(!busy && !irq_ack && !stk_we, "R5 ack single cycle", irq_ack, 0);
    chk(sp_m == sp0 - 2, "R4 sp down by two", sp_m, sp0 - 2);
    chk(gie_m == 0, "R5 gie cleared", gie_m, 0);
    chk(mem[sp0] == rpc[7:0] && mem[sp0-1] == {4'h0, rpc[11:8]}, "R7 stack bytes",
        {mem[sp0-1], mem[sp0]}, {4'h0, rpc[11:8], rpc[7:0]});
  endtask

  task automatic t_return(input logic [PC_W-1:0] exp_pc, input bit noise);
    logic [SP_W-1:0] sp0;
    int writes = 0;
    @(negedge clk);
    sp0 = sp_m;
    reti_dec = 1;
    @(negedge clk);
    reti_dec = 0;
    if (noise) begin insn_done = 1; reti_dec = 1; end
    chk(stk_re && sp_inc && !stk_we && stk_addr == sp0 + 1, "R6 pop high addr", stk_addr, sp0 + 1);
    @(negedge clk);
    chk(stk_re && sp_inc && stk_addr == sp0 + 2, "R6 pop low addr", stk_addr, sp0 + 2);
    @(negedge clk);
    chk(busy && !stk_re && !stk_we && !pc_load, "R8 busy ignores inputs", {stk_re, stk_we}, 0);
    insn_done = 0; reti_dec = 0;
    @(negedge clk);
    chk(pc_load && gie_set && pc_load_val == exp_pc, "R6 return load", pc_load_val, exp_pc);
    @(negedge clk);
    chk(!busy && sp_m == sp0 + 2 && gie_m == 1, "R6 sp and gie restored", sp_m, sp0 + 2);
    if (stk_we) writes++;
    chk(writes == 0, "R7 no writes on return", writes, 0);
  endtask

  task automatic t_one_after_return;
    irq_pending = 1;
    @(negedge clk); quiet_cycle("R8 no entry before boundary");
    @(negedge clk); quiet_cycle("R8 no entry before boundary 2");
    irq_pending = 0;
  endtask

  task automatic t_precedence;
    @(negedge clk);
    irq_pending = 1; insn_done = 1; reti_dec = 1; irq_vector = 12'h080;
    @(negedge clk);
    insn_done = 0; reti_dec = 0; irq_pending = 0;
    chk(stk_re && !stk_we, "R9 return wins", {stk_re, stk_we}, 2);
    repeat (3) @(negedge clk);
    chk(gie_set && !irq_ack, "R9 return completes", {gie_set, irq_ack}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    set_gie(1);
    t_entry(12'h2C4, 12'hA5C, 0);
    t_return(12'hA5C, 0);
    t_entry(12'h340, 12'h7F1, 1);
    t_return(12'h7F1, 1);
    t_one_after_return();
    t_entry(12'h120, 12'h0FE, 0);
    set_gie(1);
    t_precedence();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule